// File: doc/BRIEF.md
# Two-Wire Control Bus Redirect Switch

This block watches a host two-wire control bus (a clock line and a data line) and decides which of three downstream places the bus is connected to: the device's own register bank, an external configuration PROM port, or a display DDC port. It only decides. It produces one enable for each downstream pass-through and a strobe for register traffic. The pass-through itself, the pull-ups and the register contents are handled elsewhere.

After reset the bus goes to the PROM port, and the switch observes the traffic. When it sees an address byte carrying the device's own address, it takes the bus for the register bank. While the bus is on the register bank, the register logic can issue an opcode write that chooses the next destination, PROM or DDC. That choice takes effect at the next STOP. While the bus is on the DDC, a START followed by a STOP returns the bus to the register bank. Both bus lines pass through a two-flop synchroniser and a two-sample glitch filter before any condition is detected.

Top module: `twbus_route_switch`

## Requirements
- R1: While `rst` is high, and after it is released, the route is PROM: `route_o` = 00, `prom_en` = 1, `reg_en` = 0, `ddc_en` = 0 and `reg_strobe` = 0.
- R2: While on the PROM route, an address byte is the first byte after START, sent most significant bit first. If its upper seven bits equal the device address, the route becomes internal as soon as the byte's eighth bit is sampled, before the ACK clock and before any STOP. The device address is byte value 72h when `addr_sel` = 0 and 70h when `addr_sel` = 1. The read/write bit (bit 0) is ignored, so 72h/73h or 70h/71h both match.
- R3: An address byte that does not match leaves the route on PROM.
- R4: `addr_sel` picks the address. With `addr_sel` = 1, the byte 72h does not match and 70h does. With `addr_sel` = 0 it is the other way round.
- R5: While the route is internal, a one-cycle `op_wr` records a pending destination: `op_sel` = 0 selects PROM and `op_sel` = 1 selects DDC. The route does not change until the next STOP, and then it moves to the pending destination.
- R6: While the route is DDC, a STOP that follows a START seen on that route returns the route to internal. A STOP with no START before it on that route leaves the route on DDC.
- R7: `op_wr` has no effect while the route is not internal. No pending destination is left behind by it.
- R8: `reg_strobe` is a one-cycle pulse for each byte completed while the route is internal. This includes the address byte that takes the bus. No pulse occurs for bytes on the PROM or DDC routes.
- R9: `route_o` encodes the route as 00 for PROM, 01 for internal and 10 for DDC. Exactly one of `prom_en`, `reg_en` and `ddc_en` is high, and it matches `route_o`.
- R10: A data-line pulse lasting one clock cycle is filtered out. If it occurs while the clock line is high, it is seen as neither START nor STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Host bus clock line (asynchronous) |
| sda_in | input | 1 | Host bus data line (asynchronous) |
| addr_sel | input | 1 | Address select: 0 gives 72h, 1 gives 70h |
| op_wr | input | 1 | One-cycle opcode write from the register logic |
| op_sel | input | 1 | Opcode destination: 0 PROM, 1 DDC |
| prom_en | output | 1 | Enable for the PROM pass-through |
| reg_en | output | 1 | Bus connected to the internal registers |
| ddc_en | output | 1 | Enable for the DDC pass-through |
| route_o | output | 2 | Current route code, readable for test |
| reg_strobe | output | 1 | One-cycle pulse per byte completed on the internal route |

## Verification
The bench checks that the route changes while the address byte is still in progress. A design that waited for STOP to take the bus would leave `prom_en` high through the whole transaction. The bench issues an opcode and checks that the route holds until STOP. A design that applied the opcode at once would switch mid-transfer. The bench also sends a STOP with no START while on the DDC route, and a one-cycle data glitch while the clock line is high. A switch without the START qualifier or without the filter would return to the register bank on either of these. The bench drives `op_wr` while the route is not internal and then checks that a later STOP on the internal route changes nothing. A design that latched that opcode anyway would leave the internal route unexpectedly.

// File: rtl/twr_pkg.sv
package twr_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        RT_PROM = 2'b00,
        RT_INT  = 2'b01,
        RT_DDC  = 2'b10
    } route_e;

    typedef struct packed {
        logic              done;
        logic              is_addr;
        logic [BYTE_W-1:0] data;
    } byte_evt_t;

    // Seven-bit device address; the low bit is the inverted select input.
    function automatic logic [6:0] dev_addr(input logic addr_sel);
        return {6'b011100, ~addr_sel};
    endfunction

endpackage

// File: rtl/twr_line_filter.sv
module twr_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic [FILT_LEN-1:0]    hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            hist_q <= '1;
            dout   <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], din};
            hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
            if (&hist_q)
                dout <= 1'b1;
            else if (~|hist_q)
                dout <= 1'b0;
        end
    end
endmodule

// File: rtl/twr_bus_rx.sv
module twr_bus_rx
    import twr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      scl,
    input  logic      sda,
    output logic      start_p,
    output logic      stop_p,
    output byte_evt_t evt
);
    localparam int CW = $clog2(BYTE_W + 1);

    logic              scl_d, sda_d;
    logic              active, first;
    logic [CW-1:0]     cnt;
    logic [BYTE_W-1:0] sr;

    logic scl_rise, start_c, stop_c;
    always_comb begin
        scl_rise = scl & ~scl_d;
        start_c  = scl & scl_d & sda_d & ~sda;
        stop_c   = scl & scl_d & ~sda_d & sda;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d   <= 1'b1;
            sda_d   <= 1'b1;
            start_p <= 1'b0;
            stop_p  <= 1'b0;
            active  <= 1'b0;
            first   <= 1'b0;
            cnt     <= '0;
            sr      <= '0;
            evt     <= '0;
        end else begin
            scl_d    <= scl;
            sda_d    <= sda;
            start_p  <= start_c;
            stop_p   <= stop_c;
            evt.done <= 1'b0;
            if (start_c) begin
                active <= 1'b1;
                first  <= 1'b1;
                cnt    <= '0;
            end else if (stop_c) begin
                active <= 1'b0;
            end else if (scl_rise && active) begin
                if (cnt == CW'(BYTE_W)) begin
                    cnt   <= '0;
                    first <= 1'b0;
                end else begin
                    sr  <= {sr[BYTE_W-2:0], sda};
                    cnt <= cnt + 1'b1;
                    if (cnt == CW'(BYTE_W - 1)) begin
                        evt.done    <= 1'b1;
                        evt.is_addr <= first;
                        evt.data    <= {sr[BYTE_W-2:0], sda};
                    end
                end
            end
        end
    end
endmodule

// File: rtl/twr_route_ctl.sv
module twr_route_ctl
    import twr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start_p,
    input  logic      stop_p,
    input  byte_evt_t evt,
    input  logic      addr_sel,
    input  logic      op_wr,
    input  logic      op_sel,
    output route_e    route_q,
    output logic      reg_strobe
);
    route_e pend_q;
    logic   pend_vld;
    logic   seen_start;
    route_e nxt;
    logic   addr_hit;

    always_comb begin
        addr_hit = evt.done && evt.is_addr &&
                   (evt.data[BYTE_W-1:1] == dev_addr(addr_sel));
        nxt = route_q;
        case (route_q)
            RT_PROM: if (addr_hit)              nxt = RT_INT;
            RT_INT:  if (stop_p && pend_vld)    nxt = pend_q;
            RT_DDC:  if (stop_p && seen_start)  nxt = RT_INT;
            default:                            nxt = RT_PROM;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            route_q    <= RT_PROM;
            pend_q     <= RT_PROM;
            pend_vld   <= 1'b0;
            seen_start <= 1'b0;
            reg_strobe <= 1'b0;
        end else begin
            route_q    <= nxt;
            reg_strobe <= evt.done && (nxt == RT_INT);
            if (nxt != route_q) begin
                pend_vld   <= 1'b0;
                seen_start <= 1'b0;
            end else begin
                if (op_wr && route_q == RT_INT) begin
                    pend_q   <= op_sel ? RT_DDC : RT_PROM;
                    pend_vld <= 1'b1;
                end
                if (start_p && route_q == RT_DDC)
                    seen_start <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/twbus_route_switch.sv
module twbus_route_switch
    import twr_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic       addr_sel,
    input  logic       op_wr,
    input  logic       op_sel,
    output logic       prom_en,
    output logic       reg_en,
    output logic       ddc_en,
    output logic [1:0] route_o,
    output logic       reg_strobe
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw_l, filt_l;
    logic              start_p, stop_p;
    byte_evt_t         evt;
    route_e            route_q;

    assign raw_l = {sda_in, scl_in};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        twr_line_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) u_filt (
            .clk (clk),
            .rst (rst),
            .din (raw_l[g]),
            .dout(filt_l[g])
        );
    end

    twr_bus_rx u_rx (
        .clk    (clk),
        .rst    (rst),
        .scl    (filt_l[0]),
        .sda    (filt_l[1]),
        .start_p(start_p),
        .stop_p (stop_p),
        .evt    (evt)
    );

    twr_route_ctl u_ctl (
        .clk       (clk),
        .rst       (rst),
        .start_p   (start_p),
        .stop_p    (stop_p),
        .evt       (evt),
        .addr_sel  (addr_sel),
        .op_wr     (op_wr),
        .op_sel    (op_sel),
        .route_q   (route_q),
        .reg_strobe(reg_strobe)
    );

    always_comb begin
        route_o = route_q;
        prom_en = (route_q == RT_PROM);
        reg_en  = (route_q == RT_INT);
        ddc_en  = (route_q == RT_DDC);
    end
endmodule

// File: rtl/twr_route_chk.sv
module twr_route_chk (
    input logic       clk,
    input logic       rst,
    input logic       prom_en,
    input logic       reg_en,
    input logic       ddc_en,
    input logic [1:0] route_o,
    input logic       reg_strobe,
    input logic       stop_seen
);
    AST_RESET_PROM: assert property (@(posedge clk)
        rst |=> (route_o == 2'b00 && prom_en)); // R1

    AST_ONE_ENABLE: assert property (@(posedge clk) disable iff (rst)
        $countones({prom_en, reg_en, ddc_en}) == 1); // R9

    AST_CODE_MATCH: assert property (@(posedge clk) disable iff (rst)
        (reg_en == (route_o == 2'b01)) && (ddc_en == (route_o == 2'b10))); // R9

    AST_PROM_EXIT_INT: assert property (@(posedge clk) disable iff (rst)
        ($past(prom_en) && !prom_en) |-> reg_en); // R2

    AST_DDC_EXIT_INT: assert property (@(posedge clk) disable iff (rst)
        ($past(ddc_en) && !ddc_en) |-> (reg_en && $past(stop_seen))); // R6

    AST_INT_EXIT_STOP: assert property (@(posedge clk) disable iff (rst)
        ($past(reg_en) && !reg_en) |-> $past(stop_seen)); // R5

    AST_STROBE_INT: assert property (@(posedge clk) disable iff (rst)
        reg_strobe |-> reg_en); // R8

    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (rst)
        reg_strobe |=> !reg_strobe); // R8
endmodule

bind twbus_route_switch twr_route_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .prom_en   (prom_en),
    .reg_en    (reg_en),
    .ddc_en    (ddc_en),
    .route_o   (route_o),
    .reg_strobe(reg_strobe),
    .stop_seen (stop_p)
);

// File: tb/tb_twbus_route_switch.sv
module tb_twbus_route_switch;
    localparam int H = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_in = 1'b1, sda_in = 1'b1;
    logic addr_sel = 1'b0, op_wr = 1'b0, op_sel = 1'b0;
    logic prom_en, reg_en, ddc_en, reg_strobe;
    logic [1:0] route_o;

    int checks = 0, fails = 0, strobes = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    twbus_route_switch dut (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
        .addr_sel(addr_sel), .op_wr(op_wr), .op_sel(op_sel),
        .prom_en(prom_en), .reg_en(reg_en), .ddc_en(ddc_en),
        .route_o(route_o), .reg_strobe(reg_strobe)
    );

    always @(posedge clk) if (!rst && reg_strobe) strobes++;

    // {addr_sel, address byte, expected route, match}
    localparam logic [11:0] VEC [8] = '{
        {1'b0, 8'h72, 2'b01, 1'b1},
        {1'b0, 8'h73, 2'b01, 1'b1},
        {1'b0, 8'h70, 2'b00, 1'b0},
        {1'b1, 8'h70, 2'b01, 1'b1},
        {1'b1, 8'h71, 2'b01, 1'b1},
        {1'b1, 8'h72, 2'b00, 1'b0},
        {1'b0, 8'hA0, 2'b00, 1'b0},
        {1'b1, 8'hF0, 2'b00, 1'b0}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; scl_in = 1'b1; sda_in = 1'b1; op_wr = 1'b0;
        hold(5);
        rst = 1'b0;
        hold(10);
    endtask

    task automatic bus_start();
        sda_in = 1'b1; scl_in = 1'b1; hold(H);
        sda_in = 1'b0; hold(H);
        scl_in = 1'b0; hold(H);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_in = b[i]; hold(H);
            scl_in = 1'b1; hold(H);
            scl_in = 1'b0; hold(H);
        end
        sda_in = 1'b1; hold(H);
        scl_in = 1'b1; hold(H);
        scl_in = 1'b0; hold(H);
    endtask

    task automatic bus_stop();
        scl_in = 1'b0; hold(H);
        sda_in = 1'b0; hold(H);
        scl_in = 1'b1; hold(H);
        sda_in = 1'b1; hold(3 * H);
    endtask

    task automatic pulse_op(input logic sel);
        op_sel = sel; op_wr = 1'b1; hold(1);
        op_wr = 1'b0; hold(2);
    endtask

    initial begin
        int s0;
        // R1 reset state
        @(negedge clk); @(negedge clk);
        chk("R1 route in reset", route_o, 0);
        chk("R1 prom_en in reset", prom_en, 1);
        do_reset();
        chk("R1 route after reset", route_o, 0);
        chk("R9 enables after reset", {prom_en, reg_en, ddc_en}, 3'b100);
        chk("R1 strobe after reset", reg_strobe, 0);

        // table walk: R2 R3 R4 R8
        for (int i = 0; i < 8; i++) begin
            logic [11:0] v;
            v = VEC[i];
            do_reset();
            addr_sel = v[11];
            s0 = strobes;
            bus_start();
            send_byte(v[10:3]);
            send_byte(8'h5A);
            bus_stop();
            chk("R2 R3 R4 route after transaction", route_o, v[2:1]);
            chk("R8 strobe count", strobes - s0, v[0] ? 2 : 0);
        end

        // R2 takeover before STOP
        addr_sel = 1'b0;
        do_reset();
        bus_start();
        send_byte(8'h72);
        chk("R2 reg_en mid transaction", reg_en, 1);
        chk("R2 prom_en mid transaction", prom_en, 0);

        // R5 opcode to DDC held until STOP
        send_byte(8'h11);
        pulse_op(1'b1);
        chk("R5 route held before STOP", route_o, 1);
        bus_stop();
        chk("R5 route DDC after STOP", route_o, 2);
        chk("R9 ddc enable only", {prom_en, reg_en, ddc_en}, 3'b001);

        // R10 one-cycle glitch with clock high
        sda_in = 1'b0; hold(1);
        sda_in = 1'b1; hold(20);
        chk("R10 glitch ignored", route_o, 2);

        // R6 STOP without START
        bus_stop();
        chk("R6 lone STOP ignored", route_o, 2);

        // R7 opcode outside internal route
        pulse_op(1'b0);
        s0 = strobes;
        bus_start();
        send_byte(8'hA0);
        chk("R6 still DDC before STOP", route_o, 2);
        bus_stop();
        chk("R6 back to internal", route_o, 1);
        chk("R8 no strobe on DDC byte", strobes - s0, 0);
        bus_start();
        send_byte(8'h72);
        bus_stop();
        chk("R7 stale opcode not kept", route_o, 1);

        // R5 opcode to PROM
        pulse_op(1'b0);
        s0 = strobes;
        bus_start();
        send_byte(8'h72);
        bus_stop();
        chk("R5 route PROM after STOP", route_o, 0);
        chk("R8 strobe on internal byte", strobes - s0, 1);
        chk("R9 prom enable only", {prom_en, reg_en, ddc_en}, 3'b100);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule